// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block sends pairs of 24-bit two's-complement audio samples over a three-wire serial link. The three wires are a bit clock, a frame clock and a data line. A parallel left/right sample pair is written into a holding stage with a load strobe. Each sample is then shifted out MSB first, one bit for each falling edge of the bit clock. A single format input selects between two framings. In left-justified framing, a high frame clock marks the left channel and the MSB fills the first slot. In I2S framing, a low frame clock marks the left channel and the MSB is one slot late.

The block has two clocking modes. In master mode it divides the system clock to make its own bit clock and frame clock. The frame is fixed at 64 bit clocks: two 32-slot halves with a 50% frame-clock duty cycle. In slave mode it synchronizes an external bit clock and frame clock into the system clock domain and follows them. A run input powers the port down: while it is low, the data line is driven low and, in master mode, both clocks are driven low.

Top module: `aud_ser_tx`

## Requirements
- R1: Each channel word is sent MSB first as 24 bits of two's-complement data, left half-frame first.
- R2: `sdata_o` changes only after a falling edge of the bit clock and stays stable while the bit clock is high.
- R3: With `i2s_i` = 0 (left-justified), the left half is marked by frame clock = 1 and the word's MSB occupies slot 0 of its half-frame.
- R4: With `i2s_i` = 1 (I2S), the left half is marked by frame clock = 0, slot 0 carries 0 and the MSB occupies slot 1.
- R5: With `master_i` = 1, `bclk_o` has a period of 2*DIV_HALF system clocks, and a frame has 64 bit clocks. `lrclk_o` is at each level for 32 bit clocks and changes only together with a falling edge of `bclk_o`.
- R6: `clk_oe_o` equals `master_i`. With `master_i` = 0, `bclk_o` and `lrclk_o` stay 0 and timing is taken from `bclk_i`/`lrclk_i`.
- R7: While `run_i` = 0, `sdata_o`, `bclk_o` and `lrclk_o` are 0 from the next system clock onwards. This also holds after reset.
- R8: Slots outside the data window are sent as 0. In left-justified framing these are slots 24..31. In I2S framing they are slot 0 and slots 25..31.
- R9: A loaded pair becomes active only at the start of a left half-frame. A load made mid-frame leaves the current frame unchanged and appears in the next frame.
- R10: In slave mode, the data bit for a slot is on `sdata_o` within 4 system clocks of the external bit-clock falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | 1 = operate, 0 = power-down |
| master_i | input | 1 | 1 = generate clocks, 0 = follow external clocks |
| i2s_i | input | 1 | 0 = left-justified, 1 = I2S framing |
| load_i | input | 1 | Strobe that captures `left_i`/`right_i` |
| left_i | input | DATA_W | Left sample |
| right_i | input | DATA_W | Right sample |
| bclk_i | input | 1 | External bit clock (slave) |
| lrclk_i | input | 1 | External frame clock (slave) |
| bclk_o | output | 1 | Generated bit clock (master) |
| lrclk_o | output | 1 | Generated frame clock (master) |
| clk_oe_o | output | 1 | Drive enable for the clock pins |
| sdata_o | output | 1 | Serial data |

## Verification
In master mode, `bclk_o`, `lrclk_o` and `sdata_o` are all registered and change on the same system clock edge. The bench therefore samples each data bit at the bit-clock rising edge it observes, and confirms that the bit holds until the next fall. In slave mode, a driven falling edge reaches `sdata_o` after three system clock edges: two synchronizer stages, then the output register. The bench holds each bit-clock phase for 8 system clocks and samples at the end of the high phase. Power-down is checked one system clock after `run_i` drops. Mid-frame loads are judged over two whole frames that follow.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  // per-bit timing event shared by master and slave timing sources
  typedef struct packed {
    logic fall;    // bit clock falling edge this cycle
    logic hstart;  // this fall opens a half-frame
    logic left;    // current half carries the left word
  } bit_evt_t;
endpackage

// File: rtl/aud_tx_mclkgen.sv
module aud_tx_mclkgen
  import aud_tx_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int HALF_W   = 32
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  logic     i2s_i,
  output logic     bclk_o,
  output logic     lrclk_o,
  output bit_evt_t evt_o
);
  localparam int FRAME_W = 2 * HALF_W;
  localparam int CW      = $clog2(FRAME_W);
  localparam int DCW     = $clog2(DIV_HALF + 1);

  logic [DCW-1:0] dcnt;
  logic [CW-1:0]  bcnt, bcnt_nx;
  logic           bclk_q, lrck_q, tick;

  assign tick    = (dcnt == DCW'(DIV_HALF - 1));
  assign bcnt_nx = bcnt + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcnt   <= '0;
      bclk_q <= 1'b0;
      lrck_q <= 1'b0;
      bcnt   <= '1;
    end else if (!run_i) begin
      dcnt   <= '0;
      bclk_q <= 1'b0;
      lrck_q <= 1'b0;
      bcnt   <= '1;
    end else begin
      dcnt <= tick ? '0 : dcnt + 1'b1;
      if (tick) begin
        bclk_q <= ~bclk_q;
        if (bclk_q) begin
          bcnt   <= bcnt_nx;
          // left half: high for left-justified, low for I2S
          lrck_q <= bcnt_nx[CW-1] ^ ~i2s_i;
        end
      end
    end
  end

  assign evt_o.fall   = run_i & tick & bclk_q;
  assign evt_o.hstart = evt_o.fall & (bcnt_nx[CW-2:0] == '0);
  assign evt_o.left   = ~bcnt_nx[CW-1];
  assign bclk_o       = bclk_q;
  assign lrclk_o      = lrck_q;

  // R5
  lrck_at_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && $past(run_i, 2) && ($past(i2s_i) == $past(i2s_i, 2))
     && (lrck_q != $past(lrck_q))) |-> ($past(bclk_q) && !bclk_q));

  // R7
  pdn_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!bclk_q && !lrck_q));

endmodule

// File: rtl/aud_tx_slvsync.sv
module aud_tx_slvsync
  import aud_tx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  logic     i2s_i,
  input  logic     bclk_i,
  input  logic     lrclk_i,
  output bit_evt_t evt_o
);
  logic [1:0] bsync, lsync;
  logic       bclk_d, lrck_last, fall;

  assign fall = run_i & bclk_d & ~bsync[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bsync     <= '0;
      lsync     <= '0;
      bclk_d    <= 1'b0;
      lrck_last <= 1'b0;
    end else begin
      bsync  <= {bsync[0], bclk_i};
      lsync  <= {lsync[0], lrclk_i};
      bclk_d <= bsync[1];
      // track level while idle so the first edge is a real one
      if (!run_i || fall) lrck_last <= lsync[1];
    end
  end

  assign evt_o.fall   = fall;
  assign evt_o.hstart = fall & (lsync[1] ^ lrck_last);
  assign evt_o.left   = lsync[1] ^ i2s_i;

endmodule

// File: rtl/aud_tx_shift.sv
module aud_tx_shift
  import aud_tx_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int HALF_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              i2s_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  input  bit_evt_t          evt_i,
  output logic              sdata_o
);
  localparam int SW = $clog2(HALF_W) + 1;

  logic [DATA_W-1:0] hold_l, hold_r, act_l, act_r, word, sh;
  logic [SW-1:0]     slot, slot_nx;
  logic              bit_nx, in_win, sd_q, take;

  assign take    = evt_i.hstart & evt_i.left;
  assign slot_nx = evt_i.hstart ? '0 : ((slot == '1) ? slot : slot + 1'b1);
  assign word    = take ? hold_l : (evt_i.left ? act_l : act_r);
  assign sh      = word << (i2s_i ? slot_nx - 1'b1 : slot_nx);
  assign in_win  = i2s_i ? ((slot_nx != '0) && (slot_nx <= SW'(DATA_W)))
                         : (slot_nx < SW'(DATA_W));
  assign bit_nx  = in_win & sh[DATA_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_l <= '0;
      hold_r <= '0;
    end else if (load_i) begin
      hold_l <= left_i;
      hold_r <= right_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_l <= '0;
      act_r <= '0;
      slot  <= '1;
      sd_q  <= 1'b0;
    end else if (!run_i) begin
      act_l <= '0;
      act_r <= '0;
      slot  <= '1;
      sd_q  <= 1'b0;
    end else if (evt_i.fall) begin
      if (take) begin
        act_l <= hold_l;
        act_r <= hold_r;
      end
      slot <= slot_nx;
      sd_q <= bit_nx;
    end
  end

  assign sdata_o = sd_q;

  // R2
  sd_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && (sd_q != $past(sd_q))) |-> $past(evt_i.fall));

  // R8
  pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && evt_i.fall && (slot_nx > SW'(DATA_W))) |=> !sd_q);

  // R7
  pdn_sd_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !sd_q);

  // R9
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !take) |=> ($stable(act_l) && $stable(act_r)));

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_tx_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int HALF_W   = 32,
  parameter int DIV_HALF = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              master_i,
  input  logic              i2s_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  input  logic              bclk_i,
  input  logic              lrclk_i,
  output logic              bclk_o,
  output logic              lrclk_o,
  output logic              clk_oe_o,
  output logic              sdata_o
);
  bit_evt_t mst_evt, slv_evt, evt;
  logic     mst_bclk, mst_lrck;

  aud_tx_mclkgen #(
    .DIV_HALF(DIV_HALF),
    .HALF_W  (HALF_W)
  ) u_mclkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i & master_i),
    .i2s_i  (i2s_i),
    .bclk_o (mst_bclk),
    .lrclk_o(mst_lrck),
    .evt_o  (mst_evt)
  );

  aud_tx_slvsync u_slvsync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i & ~master_i),
    .i2s_i  (i2s_i),
    .bclk_i (bclk_i),
    .lrclk_i(lrclk_i),
    .evt_o  (slv_evt)
  );

  assign evt = master_i ? mst_evt : slv_evt;

  aud_tx_shift #(
    .DATA_W(DATA_W),
    .HALF_W(HALF_W)
  ) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .i2s_i  (i2s_i),
    .load_i (load_i),
    .left_i (left_i),
    .right_i(right_i),
    .evt_i  (evt),
    .sdata_o(sdata_o)
  );

  assign bclk_o   = master_i & mst_bclk;
  assign lrclk_o  = master_i & mst_lrck;
  assign clk_oe_o = master_i;

endmodule

// File: tb/aud_ser_tx_tb.sv
module aud_ser_tx_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0, master_i = 1'b0, i2s_i = 1'b0, load_i = 1'b0;
  logic [23:0] left_i = '0, right_i = '0;
  logic        bclk_i = 1'b1, lrclk_i = 1'b0;
  logic        bclk_o, lrclk_o, clk_oe_o, sdata_o;
  int          n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  aud_ser_tx u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run_i), .master_i(master_i),
    .i2s_i(i2s_i), .load_i(load_i), .left_i(left_i), .right_i(right_i),
    .bclk_i(bclk_i), .lrclk_i(lrclk_i), .bclk_o(bclk_o), .lrclk_o(lrclk_o),
    .clk_oe_o(clk_oe_o), .sdata_o(sdata_o)
  );

  typedef struct packed {
    logic        mst;
    logic        fmt;
    logic [23:0] l;
    logic [23:0] r;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 1'b0, 24'h800001, 24'h7FFFFE},
    '{1'b1, 1'b1, 24'hA5C3F0, 24'h0F1E2D},
    '{1'b0, 1'b0, 24'h123456, 24'hFEDCBA},
    '{1'b0, 1'b1, 24'hFFFFFF, 24'h000001},
    '{1'b1, 1'b1, 24'h000000, 24'hFFFFFF},
    '{1'b0, 1'b0, 24'h5A5A5A, 24'hC00003}
  };

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic fmt, input logic [23:0] l, input logic [23:0] r);
    logic [63:0] f;
    logic [23:0] w;
    f = '0;
    for (int h = 0; h < 2; h++) begin
      w = (h == 0) ? l : r;
      for (int s = 0; s < 32; s++) begin
        if (!fmt && s < 24) f[63 - (h*32 + s)] = w[23 - s];
        if (fmt && s >= 1 && s <= 24) f[63 - (h*32 + s)] = w[24 - s];
      end
    end
    return f;
  endfunction

  function automatic logic [63:0] pad_mask(input logic fmt);
    logic [63:0] m;
    m = '0;
    for (int h = 0; h < 2; h++)
      for (int s = 0; s < 32; s++)
        if (fmt ? (s == 0 || s > 24) : (s >= 24)) m[63 - (h*32 + s)] = 1'b1;
    return m;
  endfunction

  task automatic load_pair(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    left_i = l; right_i = r; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic cap_mst(input logic fmt, output logic [63:0] bits, output int bad,
                         output int lr_hi, output int span);
    logic prev_b, prev_lr, lvl, snap;
    int   n, c0;
    lvl = ~fmt; prev_b = bclk_o; prev_lr = lrclk_o; n = -1;
    bad = 0; lr_hi = 0; span = 0; bits = '0; snap = 1'b0; c0 = 0;
    while (n < 64) begin
      @(negedge clk);
      if (bclk_o && !prev_b) begin
        if (n < 0) begin
          if (lrclk_o == lvl && prev_lr != lvl) n = 0;
          prev_lr = lrclk_o;
        end
        if (n >= 0) begin
          if (n == 0) c0 = cyc;
          if (n == 63) span = cyc - c0;
          bits[63 - n] = sdata_o;
          lr_hi += int'(lrclk_o);
          snap = sdata_o;
          n++;
        end
      end else if (bclk_o && n > 0 && sdata_o != snap) begin
        bad++;
      end
      prev_b = bclk_o;
    end
  endtask

  task automatic drv_slv(input logic fmt, input int ld_at, input logic [23:0] nl,
                         input logic [23:0] nr, output logic [63:0] bits);
    bits = '0;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      bclk_i = 1'b0;
      lrclk_i = (k < 32) ? ~fmt : fmt;
      if (k == ld_at) begin
        @(negedge clk);
        left_i = nl; right_i = nr; load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        repeat (6) @(negedge clk);
      end else begin
        repeat (8) @(negedge clk);
      end
      bclk_i = 1'b1;
      repeat (7) @(negedge clk);
      bits[63 - k] = sdata_o;
    end
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] bits, ef;
    int bad, lr_hi, span;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // reset state, R7
    chk({sdata_o, bclk_o, lrclk_o} == 3'b000, "R7", {61'd0, sdata_o, bclk_o, lrclk_o}, 64'd0);

    foreach (VECS[i]) begin
      vec_t v;
      v = VECS[i];
      run_i = 1'b0;
      repeat (4) @(negedge clk);
      master_i = v.mst; i2s_i = v.fmt;
      lrclk_i = v.fmt; bclk_i = 1'b1;
      @(negedge clk);
      chk({sdata_o, bclk_o, lrclk_o} == 3'b000, "R7", {61'd0, sdata_o, bclk_o, lrclk_o}, 64'd0);
      chk(clk_oe_o == v.mst, "R6", {63'd0, clk_oe_o}, {63'd0, v.mst});
      load_pair(v.l, v.r);
      run_i = 1'b1;
      ef = exp_frame(v.fmt, v.l, v.r);
      if (v.mst) begin
        cap_mst(v.fmt, bits, bad, lr_hi, span);
        chk(bits == ef, v.fmt ? "R4" : "R3", bits, ef);
        chk((v.fmt ? bits[62:39] : bits[63:40]) == v.l, "R1",
            {40'd0, v.fmt ? bits[62:39] : bits[63:40]}, {40'd0, v.l});
        chk((bits & pad_mask(v.fmt)) == '0, "R8", bits & pad_mask(v.fmt), 64'd0);
        chk(bad == 0, "R2", 64'(bad), 64'd0);
        chk(lr_hi == 32, "R5", 64'(lr_hi), 64'd32);
        chk(span == 252, "R5", 64'(span), 64'd252);
        if (i == 0) begin
          // R9: new pair takes effect at the next left half start
          load_pair(~v.l, ~v.r);
          cap_mst(v.fmt, bits, bad, lr_hi, span);
          ef = exp_frame(v.fmt, ~v.l, ~v.r);
          chk(bits == ef, "R9", bits, ef);
        end
      end else begin
        repeat (4) @(negedge clk);
        drv_slv(v.fmt, -1, '0, '0, bits);
        chk(bits == ef, v.fmt ? "R4 R10" : "R3 R10", bits, ef);
        chk((bits & pad_mask(v.fmt)) == '0, "R8", bits & pad_mask(v.fmt), 64'd0);
        chk({bclk_o, lrclk_o} == 2'b00, "R6", {62'd0, bclk_o, lrclk_o}, 64'd0);
        // R9: load mid-frame (right half) must not alter this frame
        drv_slv(v.fmt, 40, ~v.l, ~v.r, bits);
        chk(bits == ef, "R9", bits, ef);
        drv_slv(v.fmt, -1, '0, '0, bits);
        ef = exp_frame(v.fmt, ~v.l, ~v.r);
        chk(bits == ef, "R9", bits, ef);
      end
    end

    // R7: power-down while master runs
    run_i = 1'b0;
    repeat (3) @(negedge clk);
    master_i = 1'b1; i2s_i = 1'b0;
    load_pair(24'hFFFFFF, 24'hFFFFFF);
    run_i = 1'b1;
    repeat (101) @(negedge clk);
    run_i = 1'b0;
    @(negedge clk);
    chk({sdata_o, bclk_o, lrclk_o} == 3'b000, "R7", {61'd0, sdata_o, bclk_o, lrclk_o}, 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule